// File: doc/BRIEF.md
# Chained DMA Address and Count Engine

This block is the address and count engine of one DMA channel that walks a list of memory buffers back to back. That is how one channel scatters an incoming stream across several memory regions, or gathers several regions into one outgoing stream. Software writes a start address and a unit count into a staging register set. A start pulse moves the staged buffer into the working set, which drives the transfers. The staging set is then free to take the next buffer while the current one is in progress.

Each transfer request from the I/O side produces one strobe with a 32-bit memory address. When the working count runs out and a staged buffer is waiting, the engine swaps it in on the same edge, so the stream continues with no idle cycle. It then raises a completion flag: an interrupt request if the CPU staged that buffer, or a terminal-count flag if a bus master did. The next staging write clears the flag. If no buffer is waiting when the count runs out, the engine raises terminal count and stops.

Top module: `dma_chain_engine`

## Requirements
- R1: While `rst` is high, on every clock edge `active`, `xfer_stb`, `irq_out` and `tc_out` become 0 and `mem_addr` becomes 0.
- R2: A `cfg_wr` pulse stages `cfg_addr`, `cfg_count` and `cfg_owner` and marks the stage pending. A `chain_start` pulse while idle with a buffer pending loads that buffer into the working set, sets `active` after the edge and clears the pending mark. A `chain_start` with nothing pending leaves `active` at 0.
- R3: Each cycle in which `xfer_req` and `active` are both high produces `xfer_stb` = 1 after that edge, with `mem_addr` holding the working address. After the strobe the working address moves forward by the unit size latched at start: code 00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes.
- R4: `cfg_count` holds the number of units minus one, so a buffer ends after `cfg_count`+1 strobes. A count of 0 gives exactly one strobe.
- R5: When a buffer ends and a staged buffer is pending, the next strobe uses the staged start address with no gap cycle. If that staged buffer was written with `cfg_owner` = 0 (CPU), `irq_out` rises with the last strobe of the old buffer.
- R6: Under the same conditions with `cfg_owner` = 1 (bus master), `tc_out` rises instead and `irq_out` stays low.
- R7: A `cfg_wr` clears both `irq_out` and `tc_out` after its edge, unless a buffer ends on the same edge.
- R8: When a buffer ends with nothing pending, `tc_out` rises with the last strobe and `active` falls on the same edge. Later requests produce no strobe.
- R9: Address arithmetic is a full 32 bits and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Staging write strobe |
| cfg_addr | input | 32 | Start byte address of the staged buffer |
| cfg_count | input | CNT_W | Units in the staged buffer minus one |
| cfg_owner | input | 1 | 0 = CPU, 1 = bus master staged this buffer |
| unit_size | input | 2 | Unit size code, latched at start |
| chain_start | input | 1 | Enables chaining and loads the first buffer |
| xfer_req | input | 1 | Request for one unit transfer |
| xfer_stb | output | 1 | One unit transfer issued |
| mem_addr | output | 32 | Byte address of the issued unit |
| active | output | 1 | Working set is running |
| irq_out | output | 1 | Chained completion for a CPU-staged buffer |
| tc_out | output | 1 | Terminal count or chained completion for a bus master |

## Verification
A request sampled at an edge shows its strobe and address one cycle later, because the output register is the only stage on that path. The completion flags and the swap to the staged buffer appear on the same edge as the last strobe of a buffer. A staging write clears the flags one edge after it is sampled, and `active` follows a start pulse by one edge. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so every registered result is read exactly one edge after its cause. Streams are recorded cycle by cycle and compared against address lists built from the programmed start, size and count.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [1:0] {
    UNIT_BYTE  = 2'b00,
    UNIT_HALF  = 2'b01,
    UNIT_WORD  = 2'b10,
    UNIT_WORDX = 2'b11
  } unit_e;

  // bytes advanced per unit for a size code
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (unit_e'(code))
      UNIT_BYTE: unit_bytes = 3'd1;
      UNIT_HALF: unit_bytes = 3'd2;
      default:   unit_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_chain_shadow.sv
module dma_chain_shadow #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic              wr_owner,
  input  logic              take,
  output logic [ADDR_W-1:0] sh_addr,
  output logic [CNT_W-1:0]  sh_cnt,
  output logic              sh_owner,
  output logic              sh_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_addr  <= '0;
      sh_cnt   <= '0;
      sh_owner <= 1'b0;
      sh_valid <= 1'b0;
    end else if (wr) begin
      // a fresh write wins over a take on the same edge
      sh_addr  <= wr_addr;
      sh_cnt   <= wr_cnt;
      sh_owner <= wr_owner;
      sh_valid <= 1'b1;
    end else if (take) begin
      sh_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chain_cursor.sv
module dma_chain_cursor
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              size_load,
  input  logic [1:0]        size_in,
  input  logic              step_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              exhaust
);

  localparam int DEC_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        size_q;
  logic [DEC_W-1:0]  dec;
  logic [ADDR_W-1:0] step;

  assign dec     = {1'b0, cnt_q} - {{CNT_W{1'b0}}, 1'b1};
  assign exhaust = dec[CNT_W];   // borrow out: count underflows on this unit
  assign step    = {{(ADDR_W-3){1'b0}}, unit_bytes(size_q)};

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= 2'b00;
    end else if (size_load) begin
      size_q <= size_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      cnt_q    <= load_cnt;
    end else if (step_en) begin
      cur_addr <= cur_addr + step;
      cnt_q    <= dec[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/dma_chain_flags.sv
module dma_chain_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set_irq,
  input  logic set_tc,
  output logic irq,
  output logic tc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      tc  <= 1'b0;
    end else begin
      if (set_irq)  irq <= 1'b1;
      else if (clr) irq <= 1'b0;
      if (set_tc)   tc  <= 1'b1;
      else if (clr) tc  <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_owner,
  input  logic [1:0]        unit_size,
  input  logic              chain_start,
  input  logic              xfer_req,
  output logic              xfer_stb,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              active,
  output logic              irq_out,
  output logic              tc_out
);

  logic [ADDR_W-1:0] sh_addr, cur_addr;
  logic [CNT_W-1:0]  sh_cnt;
  logic              sh_owner, sh_valid;
  logic              exhaust, start_ok, beat, last, reload, stop, take;
  logic              active_q;

  assign start_ok = chain_start & ~active_q & sh_valid;
  assign beat     = xfer_req & active_q;
  assign last     = beat & exhaust;
  assign reload   = last & sh_valid;
  assign stop     = last & ~sh_valid;
  assign take     = start_ok | reload;
  assign active   = active_q;

  dma_chain_shadow #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wr_addr(cfg_addr), .wr_cnt(cfg_count),
    .wr_owner(cfg_owner), .take(take), .sh_addr(sh_addr), .sh_cnt(sh_cnt),
    .sh_owner(sh_owner), .sh_valid(sh_valid)
  );

  dma_chain_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
    .clk(clk), .rst(rst), .load(take), .load_addr(sh_addr), .load_cnt(sh_cnt),
    .size_load(start_ok), .size_in(unit_size), .step_en(beat),
    .cur_addr(cur_addr), .exhaust(exhaust)
  );

  dma_chain_flags u_flags (
    .clk(clk), .rst(rst), .clr(cfg_wr),
    .set_irq(reload & ~sh_owner),
    .set_tc((reload & sh_owner) | stop),
    .irq(irq_out), .tc(tc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      xfer_stb <= 1'b0;
      mem_addr <= '0;
    end else begin
      if (start_ok)  active_q <= 1'b1;
      else if (stop) active_q <= 1'b0;
      xfer_stb <= beat;
      if (beat) mem_addr <= cur_addr;
    end
  end

endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker (
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic xfer_req,
  input logic active,
  input logic xfer_stb,
  input logic irq_out,
  input logic tc_out
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!active && !xfer_stb && !irq_out && !tc_out));

  assert_strobe_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> ($past(xfer_req) && $past(active)));

  assert_irq_on_last_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> (xfer_stb && !$rose(tc_out)));

  assert_tc_on_last_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tc_out) |-> xfer_stb);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> ((!irq_out && !tc_out) || xfer_stb));

  assert_stop_gives_tc_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (tc_out && xfer_stb));

endmodule

bind dma_chain_engine dma_chain_checker u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .xfer_req(xfer_req), .active(active),
  .xfer_stb(xfer_stb), .irq_out(irq_out), .tc_out(tc_out)
);

// File: tb/dma_chain_engine_test.sv
module dma_chain_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic cfg_owner = 1'b0;
  logic [1:0] unit_size = 2'b00;
  logic chain_start = 1'b0;
  logic xfer_req = 1'b0;
  logic xfer_stb, active, irq_out, tc_out;
  logic [31:0] mem_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] g_addr [16];
  logic        g_stb  [16];
  logic        g_irq  [16];
  logic        g_tc   [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_engine #(.ADDR_W(32), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_count(cfg_count),
    .cfg_owner(cfg_owner), .unit_size(unit_size), .chain_start(chain_start),
    .xfer_req(xfer_req), .xfer_stb(xfer_stb), .mem_addr(mem_addr), .active(active),
    .irq_out(irq_out), .tc_out(tc_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; xfer_req = 1'b0; cfg_wr = 1'b0; chain_start = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic stage(input logic [31:0] a, input int units, input logic own);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_count = CNT_W'(units - 1); cfg_owner = own;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic start(input logic [1:0] sz);
    @(negedge clk); chain_start = 1'b1; unit_size = sz;
    @(negedge clk); chain_start = 1'b0;
  endtask

  // hold a request for n cycles, recording one sample per cycle
  task automatic stream(input int n);
    @(negedge clk); xfer_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n-1) xfer_req = 1'b0;
      g_addr[i] = mem_addr; g_stb[i] = xfer_stb; g_irq[i] = irq_out; g_tc[i] = tc_out;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(!active && !xfer_stb && !irq_out && !tc_out, "R1 idle outputs",
        {28'd0, active, xfer_stb, irq_out, tc_out}, 32'd0);
    chk(mem_addr == 32'd0, "R1 address", mem_addr, 32'd0);
  endtask

  task automatic t_start_empty();
    do_reset();
    start(2'b00);
    chk(active == 1'b0, "R2 start with nothing pending", {31'd0, active}, 32'd0);
    stream(1);
    chk(g_stb[0] == 1'b0, "R8 no strobe while idle", {31'd0, g_stb[0]}, 32'd0);
  endtask

  task automatic t_chain_cpu();
    logic [31:0] ea [5];
    do_reset();
    stage(32'h0000_1000, 4, 1'b0);
    start(2'b00);
    chk(active == 1'b1, "R2 start loads working set", {31'd0, active}, 32'd1);
    stage(32'h0000_2000, 2, 1'b0);
    stream(4);
    for (int i = 0; i < 4; i++) begin
      chk(g_stb[i] && g_addr[i] == 32'h1000 + i, "R3 R4 byte walk buffer 1", g_addr[i], 32'h1000 + i);
      chk(g_irq[i] == (i == 3), "R5 irq at buffer 1 end", {31'd0, g_irq[i]}, {31'd0, 1'(i == 3)});
      chk(g_tc[i] == 1'b0, "R6 no tc for cpu buffer", {31'd0, g_tc[i]}, 32'd0);
    end
    stage(32'h0000_3000, 3, 1'b0);
    chk(irq_out == 1'b0, "R7 write clears irq", {31'd0, irq_out}, 32'd0);
    ea = '{32'h2000, 32'h2001, 32'h3000, 32'h3001, 32'h3002};
    stream(5);
    for (int i = 0; i < 5; i++) begin
      chk(g_stb[i] && g_addr[i] == ea[i], "R5 gapless chained addresses", g_addr[i], ea[i]);
      chk(g_tc[i] == (i == 4), "R8 tc only at final end", {31'd0, g_tc[i]}, {31'd0, 1'(i == 4)});
    end
    chk(g_irq[0] == 1'b0 && g_irq[1] == 1'b1, "R5 irq at buffer 2 end",
        {30'd0, g_irq[0], g_irq[1]}, 32'd1);
    chk(active == 1'b0, "R8 stopped", {31'd0, active}, 32'd0);
    stream(2);
    chk(!g_stb[0] && !g_stb[1], "R8 no strobes after stop", {30'd0, g_stb[0], g_stb[1]}, 32'd0);
  endtask

  task automatic t_chain_master();
    logic [31:0] ea [3];
    do_reset();
    stage(32'h0000_0100, 2, 1'b1);
    start(2'b10);
    stage(32'h0000_0200, 1, 1'b1);
    ea = '{32'h100, 32'h104, 32'h200};
    stream(3);
    for (int i = 0; i < 3; i++) begin
      chk(g_stb[i] && g_addr[i] == ea[i], "R3 R4 word steps and single-unit buffer", g_addr[i], ea[i]);
      chk(g_irq[i] == 1'b0, "R6 no irq for bus master", {31'd0, g_irq[i]}, 32'd0);
    end
    chk(g_tc[0] == 1'b0 && g_tc[1] == 1'b1, "R6 tc at chained end", {30'd0, g_tc[0], g_tc[1]}, 32'd1);
    chk(active == 1'b0 && tc_out == 1'b1, "R8 stop holds tc", {30'd0, active, tc_out}, 32'd1);
    stage(32'h0000_0300, 1, 1'b1);
    chk(tc_out == 1'b0, "R7 write clears tc", {31'd0, tc_out}, 32'd0);
  endtask

  task automatic t_wrap();
    do_reset();
    stage(32'hFFFF_FFFE, 2, 1'b0);
    start(2'b01);
    stream(2);
    chk(g_addr[0] == 32'hFFFF_FFFE, "R9 top of range", g_addr[0], 32'hFFFF_FFFE);
    chk(g_stb[1] && g_addr[1] == 32'h0, "R9 wraps to zero", g_addr[1], 32'h0);
    chk(g_tc[1] && !active, "R8 stop after wrap", {30'd0, g_tc[1], active}, 32'd2);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_start_empty();
        t_chain_cpu();
        t_chain_master();
        t_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule